// File: doc/BRIEF.md
# Solenoid Lock Pulse Driver

This block turns host writes to a small vector of lock-control bits into drive signals for software-lock solenoids, with one output lane per bit. A configuration register, which can be written only once, holds a 4-bit duration code and a speed bit. While the duration code is zero the block works in level mode, and each solenoid output copies its control bit. When the code is nonzero the block works in pulsed mode. In that mode a control bit written from 1 to 0 fires a timed pulse on its lane. The pulse lasts the code times a unit of time. The unit is one base tick when the speed bit is clear, and `LONG_RATIO` base ticks when it is set.

A single free-running prescaler supplies the base tick to all lanes. Its period of `TICK_CYCLES` clocks stands for 50 ms (200000 cycles at 4 MHz). A simulation may set it shorter. The first configuration write also clears every lock-control bit and every solenoid output. Writes after that leave the configuration and the lock state alone.

Each lane is a three-state machine. The states are `LN_IDLE` (output low), `LN_HOLD` (level mode, output high) and `LN_PULSE` (pulsed mode, output high while counting ticks). The transitions are:
- IDLE→HOLD: level mode, bit becomes 1.
- HOLD→IDLE: bit becomes 0.
- IDLE→PULSE: pulsed mode, 1-to-0 write.
- PULSE→PULSE (reload): a further 1-to-0 write.
- PULSE→IDLE: the tick that takes the count from 1.
- Any state→IDLE: the first configuration write.

Top module: `solenoid_lock_drv`

## Requirements
- R1: With duration code 0000, `sol_out` equals `lock_rdata` on every cycle. After a control write, both take the written value on the next clock edge.
- R2: With a nonzero code, a control write that takes a bit from 1 to 0 drives that lane's `sol_out` high from the clock edge of the write.
- R3: With the speed bit 0 and code K, the pulse stays high for W cycles, where (K-1)·TICK_CYCLES < W ≤ K·TICK_CYCLES.
- R4: With the speed bit 1, R3 holds with K = code·LONG_RATIO (LONG_RATIO = 16).
- R5: With code 0000, the speed bit has no effect, and the outputs still follow the control bits.
- R6: `cfg_dur_rd` and `cfg_long_rd` show the values of the first configuration write. Every later configuration write is ignored.
- R7: The first configuration write sets all control bits and all outputs to 0 on its clock edge. This clear wins over a control write in the same cycle. Later configuration writes clear nothing.
- R8: A 1-to-0 write that arrives during an active pulse reloads the full width, so R3 and R4 are counted from the new write.
- R9: In pulsed mode, a 0-to-1 write or a rewrite of the same value starts no pulse and does not end a running pulse.
- R10: After reset, the configuration, the control bits and the outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dur | input | CODE_W | Duration code to write |
| cfg_long | input | 1 | Speed bit to write (1 = long unit) |
| cfg_dur_rd | output | CODE_W | Duration code readback |
| cfg_long_rd | output | 1 | Speed bit readback |
| lock_we | input | 1 | Lock-control write strobe |
| lock_wdata | input | N_CH | New lock-control bits |
| lock_rdata | output | N_CH | Lock-control bits readback |
| sol_out | output | N_CH | Solenoid drive, one per lane |

## Verification
The bench goes after several corner cases, each paired with the fault it would expose:
- A retrigger inside a running pulse. A design that ignored the retrigger would end the pulse too early.
- A rising write in pulsed mode. A driver that fired on any write would pulse here.
- The second configuration write. A design that was not write-once would change the readback or clear the lock bits again.
- Pulse widths at the short and long extremes, and at random codes. A design that chose the wrong unit or was off by one tick would fall outside the one-tick window.

Random level-mode traffic, with the speed bit set as well as clear, catches an output that lags or ignores its bit.

// File: rtl/sol_pkg.sv
package sol_pkg;
    typedef enum logic [1:0] {
        LN_IDLE  = 2'd0,
        LN_HOLD  = 2'd1,
        LN_PULSE = 2'd2
    } lane_state_e;
endpackage

// File: rtl/sol_tick_gen.sv
module sol_tick_gen #(
    parameter int TICK_CYCLES = 200000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

    logic [CW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (!rst_n)            div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                   div_q <= div_q + 1'b1;
    end

    always_comb tick = (div_q == LAST);
endmodule

// File: rtl/sol_cfg_reg.sv
module sol_cfg_reg #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CODE_W-1:0] cfg_dur,
    input  logic              cfg_long,
    output logic [CODE_W-1:0] dur_q,
    output logic              long_q,
    output logic              clear_all
);
    logic done_q;

    always_comb clear_all = cfg_we && !done_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            dur_q  <= '0;
            long_q <= 1'b0;
        end else if (clear_all) begin
            done_q <= 1'b1;
            dur_q  <= cfg_dur;
            long_q <= cfg_long;
        end
    end
endmodule

// File: rtl/sol_lane.sv
module sol_lane
    import sol_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             level_mode,
    input  logic             ctl_next,
    input  logic             fall_ev,
    input  logic             tick,
    input  logic [CNT_W-1:0] width_ticks,
    output logic             sol
);
    lane_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        if (clear) begin
            state_d = LN_IDLE;
        end else begin
            unique case (state_q)
                LN_IDLE: begin
                    if (level_mode && ctl_next)     state_d = LN_HOLD;
                    else if (!level_mode && fall_ev) state_d = LN_PULSE;
                end
                LN_HOLD: begin
                    if (!ctl_next) state_d = LN_IDLE;
                end
                LN_PULSE: begin
                    if (fall_ev)                       state_d = LN_PULSE;
                    else if (tick && cnt_q == CNT_W'(1)) state_d = LN_IDLE;
                end
                default: state_d = LN_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LN_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (clear)                          cnt_q <= '0;
            else if (!level_mode && fall_ev)    cnt_q <= width_ticks;
            else if (state_q == LN_PULSE && tick) cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb sol = (state_q == LN_HOLD) || (state_q == LN_PULSE);
endmodule

// File: rtl/solenoid_lock_drv.sv
module solenoid_lock_drv #(
    parameter int N_CH        = 2,
    parameter int CODE_W      = 4,
    parameter int LONG_RATIO  = 16,
    parameter int TICK_CYCLES = 200000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CODE_W-1:0] cfg_dur,
    input  logic              cfg_long,
    output logic [CODE_W-1:0] cfg_dur_rd,
    output logic              cfg_long_rd,
    input  logic              lock_we,
    input  logic [N_CH-1:0]   lock_wdata,
    output logic [N_CH-1:0]   lock_rdata,
    output logic [N_CH-1:0]   sol_out
);
    localparam int MAX_TICKS = ((1 << CODE_W) - 1) * LONG_RATIO;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    logic              tick;
    logic              clear_all;
    logic [CODE_W-1:0] dur_q;
    logic              long_q;
    logic              level_mode;
    logic [CNT_W-1:0]  width_ticks;
    logic [N_CH-1:0]   ctl_q, ctl_d, fall_ev;

    sol_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    sol_cfg_reg #(.CODE_W(CODE_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dur(cfg_dur),
        .cfg_long(cfg_long), .dur_q(dur_q), .long_q(long_q),
        .clear_all(clear_all)
    );

    always_comb begin
        level_mode  = (dur_q == '0);
        width_ticks = long_q ? CNT_W'(dur_q) * CNT_W'(LONG_RATIO)
                             : CNT_W'(dur_q);
        if (clear_all)    ctl_d = '0;
        else if (lock_we) ctl_d = lock_wdata;
        else              ctl_d = ctl_q;
        fall_ev = (lock_we && !clear_all) ? (ctl_q & ~lock_wdata) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_lane
        sol_lane #(.CNT_W(CNT_W)) u_lane (
            .clk(clk), .rst_n(rst_n), .clear(clear_all),
            .level_mode(level_mode), .ctl_next(ctl_d[g]),
            .fall_ev(fall_ev[g]), .tick(tick),
            .width_ticks(width_ticks), .sol(sol_out[g])
        );
    end

    assign cfg_dur_rd  = dur_q;
    assign cfg_long_rd = long_q;
    assign lock_rdata  = ctl_q;
endmodule

// File: rtl/sol_pulse_chk.sv
module sol_pulse_chk #(
    parameter int N_CH   = 2,
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [CODE_W-1:0] cfg_dur_rd,
    input logic              cfg_long_rd,
    input logic              lock_we,
    input logic [N_CH-1:0]   lock_wdata,
    input logic [N_CH-1:0]   lock_rdata,
    input logic [N_CH-1:0]   sol_out
);
    logic seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n)      seen_q <= 1'b0;
        else if (cfg_we) seen_q <= 1'b1;
    end

    a_r1_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dur_rd == '0) |-> (sol_out == lock_rdata));

    a_r6_write_once: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |=> ($stable(cfg_dur_rd) && $stable(cfg_long_rd)));

    a_r7_first_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !seen_q) |=> (lock_rdata == '0 && sol_out == '0));

    for (genvar i = 0; i < N_CH; i++) begin : g_chk
        a_r2_fall_fires: assert property (@(posedge clk) disable iff (!rst_n)
            ((cfg_dur_rd != '0) && lock_we && lock_rdata[i] && !lock_wdata[i]
             && !(cfg_we && !seen_q)) |=> sol_out[i]);

        a_r9_no_false_start: assert property (@(posedge clk) disable iff (!rst_n)
            ((cfg_dur_rd != '0) && !sol_out[i]
             && !(lock_we && lock_rdata[i] && !lock_wdata[i])) |=> !sol_out[i]);
    end
endmodule

bind solenoid_lock_drv sol_pulse_chk #(.N_CH(N_CH), .CODE_W(CODE_W)) u_sol_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dur_rd(cfg_dur_rd),
    .cfg_long_rd(cfg_long_rd), .lock_we(lock_we), .lock_wdata(lock_wdata),
    .lock_rdata(lock_rdata), .sol_out(sol_out)
);

// File: tb/test_solenoid_lock_drv.sv
`timescale 1ns/1ps
module test_solenoid_lock_drv;
    localparam int N_CH = 2;
    localparam int CODE_W = 4;
    localparam int RATIO = 16;
    localparam int TICKS = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [CODE_W-1:0] cfg_dur = '0;
    logic cfg_long = 1'b0;
    logic [CODE_W-1:0] cfg_dur_rd;
    logic cfg_long_rd;
    logic lock_we = 1'b0;
    logic [N_CH-1:0] lock_wdata = '0;
    logic [N_CH-1:0] lock_rdata;
    logic [N_CH-1:0] sol_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    solenoid_lock_drv #(.N_CH(N_CH), .CODE_W(CODE_W), .LONG_RATIO(RATIO),
                        .TICK_CYCLES(TICKS)) i_solenoid_lock_drv (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dur(cfg_dur),
        .cfg_long(cfg_long), .cfg_dur_rd(cfg_dur_rd), .cfg_long_rd(cfg_long_rd),
        .lock_we(lock_we), .lock_wdata(lock_wdata), .lock_rdata(lock_rdata),
        .sol_out(sol_out)
    );

    function automatic int ticks_for(input int code, input bit lng);
        return lng ? code * RATIO : code;
    endfunction

    function automatic bit width_ok(input int w, input int k);
        return (w > (k - 1) * TICKS) && (w <= k * TICKS);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cfg_we = 1'b0; lock_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic ctl_write(input logic [N_CH-1:0] v);
        @(negedge clk);
        lock_we = 1'b1; lock_wdata = v;
        @(posedge clk); #1;
        lock_we = 1'b0;
    endtask

    task automatic cfg_write(input int code, input bit lng);
        @(negedge clk);
        cfg_we = 1'b1; cfg_dur = CODE_W'(code); cfg_long = lng;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic measure(input int lane, output int w);
        w = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (sol_out[lane]) w++;
            else break;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int w, code, k;
        bit lng;
        logic [N_CH-1:0] v;
        void'($urandom(1234));

        // R10 reset state
        do_reset();
        @(negedge clk);
        check(sol_out == 0 && lock_rdata == 0, "R10 outputs", int'(sol_out), 0);
        check(cfg_dur_rd == 0 && cfg_long_rd == 0, "R10 config", int'(cfg_dur_rd), 0);

        // R1 level mode, random traffic
        for (int i = 0; i < 20; i++) begin
            v = N_CH'($urandom % 4);
            ctl_write(v);
            @(negedge clk);
            check(sol_out == v && lock_rdata == v, "R1 follow", int'(sol_out), int'(v));
        end

        // R7 first config write clears; R6 loads
        ctl_write(2'b11);
        cfg_write(0, 1'b1);
        @(negedge clk);
        check(lock_rdata == 0 && sol_out == 0, "R7 first clear", int'(sol_out), 0);
        check(cfg_long_rd == 1'b1, "R6 first load", int'(cfg_long_rd), 1);

        // R5 speed bit ignored in level mode
        for (int i = 0; i < 20; i++) begin
            v = N_CH'($urandom % 4);
            ctl_write(v);
            @(negedge clk);
            check(sol_out == v, "R5 speed ignored", int'(sol_out), int'(v));
        end

        // R6 second write ignored; R7 no clear later
        ctl_write(2'b10);
        cfg_write(9, 1'b0);
        @(negedge clk);
        check(cfg_dur_rd == 0 && cfg_long_rd == 1'b1, "R6 write once", int'(cfg_dur_rd), 0);
        check(lock_rdata == 2'b10 && sol_out == 2'b10, "R7 no later clear", int'(sol_out), 2);

        // Pulsed mode, directed short
        do_reset();
        ctl_write(2'b11);
        cfg_write(3, 1'b0);
        @(negedge clk);
        check(sol_out == 0 && lock_rdata == 0, "R7 clear pulsed", int'(sol_out), 0);
        ctl_write(2'b01);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(sol_out == 0, "R9 rise no pulse", int'(sol_out), 0);
        end
        ctl_write(2'b01);
        @(negedge clk);
        check(sol_out == 0, "R9 same value no pulse", int'(sol_out), 0);
        ctl_write(2'b00);
        check(sol_out[1] == 1'b0, "R2 other lane quiet", int'(sol_out[1]), 0);
        measure(0, w);
        check(w > 0, "R2 pulse fires", w, 1);
        check(width_ok(w, 3), "R3 short width", w, 3 * TICKS);
        cfg_write(15, 1'b1);
        @(negedge clk);
        check(cfg_dur_rd == 3 && cfg_long_rd == 1'b0, "R6 locked", int'(cfg_dur_rd), 3);
        ctl_write(2'b01);
        ctl_write(2'b00);
        measure(0, w);
        check(width_ok(w, 3), "R6 width unchanged", w, 3 * TICKS);

        // Random codes, lane 1
        for (int it = 0; it < 6; it++) begin
            do_reset();
            code = 1 + int'($urandom % 15);
            lng = 1'($urandom % 2);
            cfg_write(code, lng);
            ctl_write(2'b10);
            ctl_write(2'b00);
            check(sol_out[0] == 1'b0, "R2 lane 0 quiet", int'(sol_out[0]), 0);
            measure(1, w);
            k = ticks_for(code, lng);
            check(width_ok(w, k), lng ? "R4 long random" : "R3 short random", w, k * TICKS);
        end

        // Extremes
        do_reset();
        cfg_write(15, 1'b1);
        ctl_write(2'b01);
        ctl_write(2'b00);
        measure(0, w);
        check(width_ok(w, ticks_for(15, 1'b1)), "R4 longest", w, 240 * TICKS);
        do_reset();
        cfg_write(1, 1'b0);
        ctl_write(2'b01);
        ctl_write(2'b00);
        measure(0, w);
        check(width_ok(w, 1), "R3 shortest", w, TICKS);

        // R8 retrigger
        do_reset();
        cfg_write(4, 1'b0);
        ctl_write(2'b01);
        ctl_write(2'b00);
        repeat (20) @(negedge clk);
        check(sol_out[0] == 1'b1, "R8 still high", int'(sol_out[0]), 1);
        ctl_write(2'b01);
        @(negedge clk);
        check(sol_out[0] == 1'b1, "R9 rise keeps pulse", int'(sol_out[0]), 1);
        ctl_write(2'b00);
        measure(0, w);
        check(width_ok(w, 4), "R8 restart width", w, 4 * TICKS);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule